// File: doc/BRIEF.md
# Checkpointed Transactional Store Buffer

This block makes a translated code region behave as one atomic transaction. When a region opens, it copies the architected register values and the program counter into shadow registers. Every store the region makes is held in a small ordered buffer, so memory does not see it yet. When the region reaches its commit point, the buffer writes its entries out to memory, one per cycle, oldest first. Loads issued inside the region look into the buffer and take data from the youngest store to the same address that fully covers the bytes they need.

If an interrupt arrives inside a region, the buffered stores are thrown away, the snapshot is presented for restore, and the interrupt is passed on. The first exception inside a region does not reach the handler. The block rolls back in the same way, raises a retry pulse that sends the routine back through the legacy decoder, and enters legacy mode. A second exception while legacy mode is set is reported to the handler. The next region start clears legacy mode.

Top module: `txn_store_buf`

## Requirements
- R1: `region_start` in the idle state captures `arch_state_i` and `arch_pc_i`. Any later rollback presents exactly those values on `restore_state` and `restore_pc`, whatever the inputs show at that time.
- R2: Stores accepted inside a region never reach `mem_wr_valid` before a commit. A load whose byte enables lie wholly inside the youngest overlapping buffered store to the same address gets `ld_hit` with that store's data. Bit i of a byte enable covers data bits 8i+7..8i.
- R3: When 16 stores are pending, `st_stall` is high and a further store is dropped, so it is never written to memory.
- R4: `commit` inside a region drains the buffer in program order, one entry per cycle on `mem_wr_valid`/`mem_wr_addr`/`mem_wr_data`/`mem_wr_be`. Once the buffer is empty the block returns to idle with `st_stall` low.
- R5: `irq` inside a region discards all pending stores. One cycle later it pulses `restore_valid` and `irq_take`. The discarded stores are neither forwarded nor written afterwards.
- R6: `exc` inside a region with legacy mode clear discards the stores and pulses `restore_valid` and `legacy_retry` one cycle later. It sets `legacy_mode` and does not pulse `exc_report`.
- R7: `exc` while `legacy_mode` is set pulses `exc_report` one cycle later, with no restore. The next `region_start` clears `legacy_mode`.
- R8: A load that overlaps the youngest overlapping buffered store to its address but needs bytes that store lacks raises `ld_replay` and not `ld_hit`.
- R9: In a single cycle, `irq` takes priority over `exc`, and a rollback takes priority over `commit`. Such a cycle pulses only `irq_take` and `restore_valid`, and it writes nothing to memory.
- R10: Outside a region, `irq` pulses `irq_take` and `exc` with legacy mode clear pulses `exc_report`, both one cycle later and neither with a restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_start | input | 1 | Opens a translated region and takes the snapshot |
| arch_state_i | input | 256 | Architected register values to snapshot |
| arch_pc_i | input | 64 | Program counter to snapshot |
| commit | input | 1 | Commit point of the current region |
| irq | input | 1 | Interrupt request |
| exc | input | 1 | Exception raised by the executing code |
| st_valid | input | 1 | Store request |
| st_addr | input | 64 | Store doubleword address |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte enables |
| st_stall | output | 1 | Store cannot be accepted this cycle |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 64 | Load doubleword address |
| ld_be | input | 8 | Load byte enables |
| ld_hit | output | 1 | Load fully served from the buffer |
| ld_data | output | 64 | Forwarded data |
| ld_replay | output | 1 | Partial overlap, the load must replay |
| mem_wr_valid | output | 1 | Drain write to memory |
| mem_wr_addr | output | 64 | Drain address |
| mem_wr_data | output | 64 | Drain data |
| mem_wr_be | output | 8 | Drain byte enables |
| restore_valid | output | 1 | Snapshot is presented for rollback |
| restore_state | output | 256 | Snapshotted register values |
| restore_pc | output | 64 | Snapshotted program counter |
| irq_take | output | 1 | Interrupt passed to the handler |
| legacy_retry | output | 1 | Re-execute the routine in legacy decode |
| exc_report | output | 1 | Exception passed to the handler |
| legacy_mode | output | 1 | A retry after an exception is in progress |

## Verification
A wrong pointer or count in the buffer shows up at once on the forwarding outputs, because a load issued the cycle after a store reads the wrong entry or misses. At drain time it shows up as a missing, extra or reordered memory write. A snapshot that was overwritten late appears as wrong values on the restore outputs one cycle after the rollback event. A retry flag stuck in the wrong state turns the second exception into another rollback, or the first into a report, one cycle after `exc`.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
   typedef enum logic [1:0] {
      TSB_IDLE   = 2'd0,
      TSB_ACTIVE = 2'd1,
      TSB_DRAIN  = 2'd2
   } tsb_state_e;
endpackage

// File: rtl/tsb_queue.sv
// Ordered store queue with youngest-match load forwarding.
module tsb_queue #(
   parameter int ADDR_W  = 64,
   parameter int DATA_W  = 64,
   parameter int DEPTH   = 16,
   parameter bit FORWARD = 1'b1,
   localparam int BE_W   = DATA_W / 8,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic [BE_W-1:0]   push_be,
   input  logic              pop,
   input  logic              clear,
   output logic              full,
   output logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic [BE_W-1:0]   head_be,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic [BE_W-1:0]   lk_be,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   output logic              lk_replay
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tsb_queue: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("tsb_queue: DATA_W must be a whole number of bytes");
   end

   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [BE_W-1:0]   be_q   [DEPTH];
   logic [PTR_W-1:0]  head_q, tail_q;
   logic [CNT_W-1:0]  count_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (push) tail_q <= tail_q + 1'b1;
         if (pop)  head_q <= head_q + 1'b1;
         count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[tail_q] <= push_addr;
         data_q[tail_q] <= push_data;
         be_q[tail_q]   <= push_be;
      end
   end

   assign full      = (count_q == CNT_W'(DEPTH));
   assign count     = count_q;
   assign head_addr = addr_q[head_q];
   assign head_data = data_q[head_q];
   assign head_be   = be_q[head_q];

   // Scan oldest to youngest; the last overlapping entry is the youngest.
   logic              found;
   logic [BE_W-1:0]   sel_be;
   logic [DATA_W-1:0] sel_data;

   always_comb begin
      logic [PTR_W-1:0] idx;
      found    = 1'b0;
      sel_be   = '0;
      sel_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         idx = head_q + PTR_W'(i);
         if (CNT_W'(i) < count_q && addr_q[idx] == lk_addr &&
             (be_q[idx] & lk_be) != '0) begin
            found    = 1'b1;
            sel_be   = be_q[idx];
            sel_data = data_q[idx];
         end
      end
   end

   if (FORWARD) begin : g_fwd
      assign lk_hit    = lk_valid && found && ((lk_be & ~sel_be) == '0);
      assign lk_replay = lk_valid && found && ((lk_be & ~sel_be) != '0);
      assign lk_data   = sel_data;
   end else begin : g_nofwd
      logic [DATA_W-1:0] unused_data;
      logic [BE_W-1:0]   unused_be;
      assign unused_data = sel_data;
      assign unused_be   = sel_be;
      assign lk_hit      = 1'b0;
      assign lk_replay   = lk_valid && found;
      assign lk_data     = '0;
   end
endmodule

// File: rtl/tsb_ckpt.sv
// Shadow copy of architected state taken at region start.
module tsb_ckpt #(
   parameter int REG_W = 64,
   parameter int NREG  = 4,
   parameter int PC_W  = 64,
   localparam int ST_W = REG_W * NREG
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            snap,
   input  logic [ST_W-1:0] state_in,
   input  logic [PC_W-1:0] pc_in,
   output logic [ST_W-1:0] state_out,
   output logic [PC_W-1:0] pc_out
);
   if (NREG < 1) begin : g_bad_nreg
      $error("tsb_ckpt: NREG must be at least 1");
   end

   logic [REG_W-1:0] shadow_q [NREG];
   logic [PC_W-1:0]  pc_q;

   for (genvar r = 0; r < NREG; r++) begin : g_shadow
      always_ff @(posedge clk) begin
         if (!rst_n)    shadow_q[r] <= '0;
         else if (snap) shadow_q[r] <= state_in[r*REG_W +: REG_W];
      end
      assign state_out[r*REG_W +: REG_W] = shadow_q[r];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    pc_q <= '0;
      else if (snap) pc_q <= pc_in;
   end
   assign pc_out = pc_q;
endmodule

// File: rtl/tsb_ctrl.sv
// Region state machine, rollback decisions and retry flag.
module tsb_ctrl
   import tsb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       region_start,
   input  logic       commit,
   input  logic       irq,
   input  logic       exc,
   input  logic       st_valid,
   input  logic       full,
   input  logic       empty,
   output tsb_state_e state,
   output logic       push,
   output logic       pop,
   output logic       clear,
   output logic       snap,
   output logic       restore_q,
   output logic       irq_take_q,
   output logic       retry_q,
   output logic       report_q,
   output logic       legacy_q
);
   tsb_state_e state_q, state_d;
   logic       active, abort_irq, abort_exc;

   assign active    = (state_q == TSB_ACTIVE);
   assign abort_irq = active && irq;
   assign abort_exc = active && exc && !irq && !legacy_q;
   assign clear     = abort_irq || abort_exc;
   assign snap      = (state_q == TSB_IDLE) && region_start;
   assign push      = active && st_valid && !full;
   assign pop       = (state_q == TSB_DRAIN) && !empty;
   assign state     = state_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         TSB_IDLE:   if (snap) state_d = TSB_ACTIVE;
         TSB_ACTIVE: begin
            if (clear)       state_d = TSB_IDLE;
            else if (commit) state_d = TSB_DRAIN;
         end
         TSB_DRAIN:  if (empty) state_d = TSB_IDLE;
         default:    state_d = TSB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= TSB_IDLE;
         restore_q  <= 1'b0;
         irq_take_q <= 1'b0;
         retry_q    <= 1'b0;
         report_q   <= 1'b0;
         legacy_q   <= 1'b0;
      end else begin
         state_q    <= state_d;
         restore_q  <= clear;
         irq_take_q <= irq;
         retry_q    <= abort_exc;
         report_q   <= exc && !irq && !abort_exc;
         if (snap)           legacy_q <= 1'b0;
         else if (abort_exc) legacy_q <= 1'b1;
      end
   end
endmodule

// File: rtl/txn_store_buf.sv
module txn_store_buf
   import tsb_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int DATA_W  = 64,
   parameter int DEPTH   = 16,
   parameter int REG_W   = 64,
   parameter int NREG    = 4,
   parameter int PC_W    = 64,
   parameter bit FORWARD = 1'b1,
   localparam int BE_W   = DATA_W / 8,
   localparam int ST_W   = REG_W * NREG,
   localparam int CNT_W  = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              region_start,
   input  logic [ST_W-1:0]   arch_state_i,
   input  logic [PC_W-1:0]   arch_pc_i,
   input  logic              commit,
   input  logic              irq,
   input  logic              exc,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic [BE_W-1:0]   st_be,
   output logic              st_stall,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [BE_W-1:0]   ld_be,
   output logic              ld_hit,
   output logic [DATA_W-1:0] ld_data,
   output logic              ld_replay,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic [BE_W-1:0]   mem_wr_be,
   output logic              restore_valid,
   output logic [ST_W-1:0]   restore_state,
   output logic [PC_W-1:0]   restore_pc,
   output logic              irq_take,
   output logic              legacy_retry,
   output logic              exc_report,
   output logic              legacy_mode
);
   tsb_state_e       state_w;
   logic             push_w, pop_w, clear_w, snap_w, full_w, empty_w;
   logic [CNT_W-1:0] count_w;
   logic             in_region;

   assign empty_w   = (count_w == '0);
   assign in_region = (state_w == TSB_ACTIVE);

   tsb_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .region_start (region_start),
      .commit       (commit),
      .irq          (irq),
      .exc          (exc),
      .st_valid     (st_valid),
      .full         (full_w),
      .empty        (empty_w),
      .state        (state_w),
      .push         (push_w),
      .pop          (pop_w),
      .clear        (clear_w),
      .snap         (snap_w),
      .restore_q    (restore_valid),
      .irq_take_q   (irq_take),
      .retry_q      (legacy_retry),
      .report_q     (exc_report),
      .legacy_q     (legacy_mode)
   );

   tsb_queue #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .DEPTH   (DEPTH),
      .FORWARD (FORWARD)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_w),
      .push_addr (st_addr),
      .push_data (st_data),
      .push_be   (st_be),
      .pop       (pop_w),
      .clear     (clear_w),
      .full      (full_w),
      .count     (count_w),
      .head_addr (mem_wr_addr),
      .head_data (mem_wr_data),
      .head_be   (mem_wr_be),
      .lk_valid  (ld_valid),
      .lk_addr   (ld_addr),
      .lk_be     (ld_be),
      .lk_hit    (ld_hit),
      .lk_data   (ld_data),
      .lk_replay (ld_replay)
   );

   tsb_ckpt #(
      .REG_W (REG_W),
      .NREG  (NREG),
      .PC_W  (PC_W)
   ) u_ckpt (
      .clk       (clk),
      .rst_n     (rst_n),
      .snap      (snap_w),
      .state_in  (arch_state_i),
      .pc_in     (arch_pc_i),
      .state_out (restore_state),
      .pc_out    (restore_pc)
   );

   assign mem_wr_valid = pop_w;
   assign st_stall     = (in_region && full_w) || (state_w == TSB_DRAIN);
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_region,
   input logic             st_valid,
   input logic             st_stall,
   input logic             irq,
   input logic             exc,
   input logic [CNT_W-1:0] count,
   input logic             mem_wr_valid,
   input logic             restore_valid,
   input logic             legacy_retry,
   input logic             exc_report,
   input logic             legacy_mode,
   input logic             ld_hit,
   input logic             ld_replay
);
   assert_push_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_region && st_valid && !st_stall && !irq && !exc) |=> count == $past(count) + 1'b1);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_drain_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (st_stall && !in_region));

   assert_rollback_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid |-> count == '0);

   assert_rollback_from_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid |-> $past(in_region));

   assert_retry_sets_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_retry |-> (legacy_mode && restore_valid));

   assert_report_no_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_report |-> (!restore_valid && !legacy_retry));

   assert_fwd_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_hit && ld_replay));
endmodule

bind txn_store_buf tsb_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tsb_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_region     (in_region),
   .st_valid      (st_valid),
   .st_stall      (st_stall),
   .irq           (irq),
   .exc           (exc),
   .count         (count_w),
   .mem_wr_valid  (mem_wr_valid),
   .restore_valid (restore_valid),
   .legacy_retry  (legacy_retry),
   .exc_report    (exc_report),
   .legacy_mode   (legacy_mode),
   .ld_hit        (ld_hit),
   .ld_replay     (ld_replay)
);

// File: tb/tb_txn_store_buf.sv
module tb_txn_store_buf;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         region_start, commit, irq, exc;
   logic [255:0] arch_state_i;
   logic [63:0]  arch_pc_i;
   logic         st_valid;
   logic [63:0]  st_addr, st_data;
   logic [7:0]   st_be;
   logic         st_stall;
   logic         ld_valid;
   logic [63:0]  ld_addr;
   logic [7:0]   ld_be;
   logic         ld_hit, ld_replay;
   logic [63:0]  ld_data;
   logic         mem_wr_valid;
   logic [63:0]  mem_wr_addr, mem_wr_data;
   logic [7:0]   mem_wr_be;
   logic         restore_valid;
   logic [255:0] restore_state;
   logic [63:0]  restore_pc;
   logic         irq_take, legacy_retry, exc_report, legacy_mode;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   txn_store_buf dut (
      .clk(clk), .rst_n(rst_n), .region_start(region_start),
      .arch_state_i(arch_state_i), .arch_pc_i(arch_pc_i),
      .commit(commit), .irq(irq), .exc(exc),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
      .st_stall(st_stall),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
      .ld_hit(ld_hit), .ld_data(ld_data), .ld_replay(ld_replay),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
      .restore_valid(restore_valid), .restore_state(restore_state),
      .restore_pc(restore_pc), .irq_take(irq_take),
      .legacy_retry(legacy_retry), .exc_report(exc_report),
      .legacy_mode(legacy_mode)
   );

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic open_region(input logic [255:0] s, input logic [63:0] pc);
      region_start = 1'b1; arch_state_i = s; arch_pc_i = pc;
      tick();
      region_start = 1'b0; arch_state_i = ~s; arch_pc_i = pc + 64'd4;
   endtask

   task automatic do_store(input logic [63:0] a, input logic [63:0] d, input logic [7:0] b);
      st_valid = 1'b1; st_addr = a; st_data = d; st_be = b;
      tick();
      st_valid = 1'b0;
   endtask

   task automatic probe(input logic [63:0] a, input logic [7:0] b);
      ld_valid = 1'b1; ld_addr = a; ld_be = b;
      #1;
   endtask

   task automatic quiet_mem(input int cycles, input string req);
      int seen = 0;
      for (int k = 0; k < cycles; k++) begin
         if (mem_wr_valid) seen++;
         tick();
      end
      chk(seen == 0, req, seen, 0);
   endtask

   task automatic t_reset();
      chk(st_stall == 1'b0, "reset st_stall", st_stall, 0);
      chk(mem_wr_valid == 1'b0, "reset mem_wr_valid", mem_wr_valid, 0);
      chk(restore_valid == 1'b0 && legacy_mode == 1'b0, "reset restore/legacy",
          {restore_valid, legacy_mode}, 0);
   endtask

   // R1, R5: snapshot survives input changes; irq rolls back and drops stores
   task automatic t_irq_rollback();
      logic [255:0] s1 = {4{64'hA5A5_0000_1111_2222}};
      open_region(s1, 64'h1000);
      do_store(64'h40, 64'hDEAD_BEEF_0000_0001, 8'hFF);
      probe(64'h40, 8'hFF);
      chk(ld_hit == 1'b1, "R2 hit before rollback", ld_hit, 1);
      ld_valid = 1'b0;
      irq = 1'b1;
      tick();
      irq = 1'b0;
      chk(restore_valid == 1'b1 && irq_take == 1'b1, "R5 restore+irq_take",
          {restore_valid, irq_take}, 2'b11);
      chk(restore_pc == 64'h1000, "R1 restore_pc", restore_pc, 64'h1000);
      chk(restore_state == s1, "R1 restore_state", restore_state, s1);
      tick();
      chk(restore_valid == 1'b0, "R5 restore single pulse", restore_valid, 0);
      probe(64'h40, 8'hFF);
      chk(ld_hit == 1'b0 && ld_replay == 1'b0, "R5 discarded store not forwarded",
          {ld_hit, ld_replay}, 0);
      ld_valid = 1'b0;
      commit = 1'b1;
      tick();
      commit = 1'b0;
      quiet_mem(4, "R5 discarded store not written");
   endtask

   // R2, R8, R4: forwarding cases then ordered drain
   task automatic t_forward_drain();
      int n = 0;
      open_region('1, 64'h2000);
      do_store(64'h80, 64'h1111_1111_1111_1111, 8'hFF);
      do_store(64'h80, 64'h2222_2222_2222_2222, 8'h0F);
      chk(mem_wr_valid == 1'b0, "R2 no write before commit", mem_wr_valid, 0);
      probe(64'h80, 8'h0F);
      chk(ld_hit && !ld_replay && ld_data == 64'h2222_2222_2222_2222,
          "R2 youngest covering store", ld_data, 64'h2222_2222_2222_2222);
      probe(64'h80, 8'hF0);
      chk(ld_hit && ld_data == 64'h1111_1111_1111_1111,
          "R2 skip non-overlapping younger", ld_data, 64'h1111_1111_1111_1111);
      probe(64'h80, 8'hFF);
      chk(ld_replay && !ld_hit, "R8 partial overlap replay", {ld_hit, ld_replay}, 2'b01);
      probe(64'h88, 8'hFF);
      chk(!ld_hit && !ld_replay, "R2 other address misses", {ld_hit, ld_replay}, 0);
      ld_valid = 1'b0;
      commit = 1'b1;
      tick();
      commit = 1'b0;
      for (int k = 0; k < 6; k++) begin
         if (mem_wr_valid) begin
            if (n == 0)
               chk(mem_wr_data == 64'h1111_1111_1111_1111 && mem_wr_be == 8'hFF &&
                   mem_wr_addr == 64'h80, "R4 first drained", mem_wr_data,
                   64'h1111_1111_1111_1111);
            else
               chk(mem_wr_data == 64'h2222_2222_2222_2222 && mem_wr_be == 8'h0F,
                   "R4 second drained", mem_wr_data, 64'h2222_2222_2222_2222);
            n++;
         end
         tick();
      end
      chk(n == 2, "R4 drain count", n, 2);
      chk(st_stall == 1'b0, "R4 idle after drain", st_stall, 0);
   endtask

   // R3, R4: fill to capacity, extra store dropped
   task automatic t_full();
      int n = 0;
      int bad = 0;
      open_region('0, 64'h3000);
      for (int i = 0; i < 16; i++) begin
         chk(st_stall == 1'b0, "R3 no stall below full", st_stall, 0);
         do_store(64'h100 + 64'(i) * 8, 64'(i), 8'hFF);
      end
      chk(st_stall == 1'b1, "R3 stall when full", st_stall, 1);
      do_store(64'h900, 64'd99, 8'hFF);
      commit = 1'b1;
      tick();
      commit = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if (mem_wr_valid) begin
            if (mem_wr_data != 64'(n)) bad++;
            n++;
         end
         tick();
      end
      chk(n == 16, "R3 exactly 16 written", n, 16);
      chk(bad == 0, "R4 program order", bad, 0);
   endtask

   // R6, R7: first exception retries, second reports, region start clears
   task automatic t_exception();
      logic [255:0] s2 = {4{64'h0123_4567_89AB_CDEF}};
      open_region(s2, 64'h4000);
      do_store(64'hC0, 64'h5, 8'h01);
      exc = 1'b1;
      tick();
      exc = 1'b0;
      chk(restore_valid && legacy_retry && legacy_mode && !exc_report,
          "R6 retry path", {restore_valid, legacy_retry, legacy_mode, exc_report}, 4'b1110);
      chk(restore_pc == 64'h4000 && restore_state == s2, "R6 restored snapshot",
          restore_pc, 64'h4000);
      tick();
      exc = 1'b1;
      tick();
      exc = 1'b0;
      chk(exc_report && !restore_valid && !legacy_retry, "R7 second exc reported",
          {exc_report, restore_valid, legacy_retry}, 3'b100);
      open_region('0, 64'h5000);
      chk(legacy_mode == 1'b0, "R7 region start clears legacy", legacy_mode, 0);
      commit = 1'b1;
      tick();
      commit = 1'b0;
      quiet_mem(3, "R6 aborted store not written");
   endtask

   // R9: irq beats exc and commit in the same cycle
   task automatic t_priority();
      open_region('0, 64'h6000);
      do_store(64'hE0, 64'h7, 8'hFF);
      irq = 1'b1; exc = 1'b1; commit = 1'b1;
      tick();
      irq = 1'b0; exc = 1'b0; commit = 1'b0;
      chk(irq_take && restore_valid && !legacy_retry && !exc_report && !legacy_mode,
          "R9 irq wins", {irq_take, restore_valid, legacy_retry, exc_report, legacy_mode},
          5'b11000);
      quiet_mem(4, "R9 no write after abort");
   endtask

   // R10: events outside any region
   task automatic t_outside();
      irq = 1'b1;
      tick();
      irq = 1'b0;
      chk(irq_take && !restore_valid, "R10 irq outside", {irq_take, restore_valid}, 2'b10);
      exc = 1'b1;
      tick();
      exc = 1'b0;
      chk(exc_report && !legacy_retry && !restore_valid, "R10 exc outside",
          {exc_report, legacy_retry, restore_valid}, 3'b100);
   endtask

   initial begin
      #4000000;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; region_start = 1'b0; commit = 1'b0; irq = 1'b0; exc = 1'b0;
      arch_state_i = '0; arch_pc_i = '0;
      st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
      ld_valid = 1'b0; ld_addr = '0; ld_be = '0;
      @(negedge clk);
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_irq_rollback();
      t_forward_drain();
      t_full();
      t_exception();
      t_priority();
      t_outside();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule